// File: doc/BRIEF.md
# Miss Holding Buffer

This block sits beside a cache bank and parks core requests that missed, keyed by the line address they need. It holds each request until the fill for that line arrives, then offers it for replay. It has one enqueue port. A flag on that port separates a fresh miss, which takes a free slot, from a replayed request that missed a second time. A replayed request goes back to its own slot and keeps its age there. A second flag lets an entry be written straight into the ready state. This covers a forced miss whose line was in fact present, and a fill for the same line that is already one stage behind.

A fill port compares a line address against every slot. All pending entries for that line wake together. The same compare also drives a match output on every cycle. Upstream uses that output to force later requests to a held line to miss, so that requests to one line commit in order. The schedule side shows the oldest ready entry. It also gives a one-cycle look-ahead copy of the valid flag, address and payload, so a downstream register can load the next replay candidate in the same cycle it pops the current one. Replays in flight are tracked in issue order. A release input frees the oldest one, and a replay re-enqueue returns the oldest one to waiting. The payload is an opaque vector.

Top module: `miss_hold_buf`

## Requirements
- R1: After reset every slot is free: sched_valid_o, sched_valid_next_o, almost_full_o and lookup_match_o are all 0.
- R2: An enqueue with enq_is_replay_i=0 and enq_ready_i=0 places the entry in a waiting state, where it is not offered on the schedule outputs.
- R3: An enqueue with enq_ready_i=1 makes the entry visible on sched_valid_o, sched_addr_o and sched_data_o from the next cycle.
- R4: With fill_i=1, every waiting entry whose line address equals fill_addr_i becomes ready in the next cycle. Entries with other addresses stay waiting.
- R5: Among ready entries the schedule outputs show the one allocated earliest, so entries for the same line replay in arrival order.
- R6: sched_valid_next_o, sched_addr_next_o and sched_data_next_o in one cycle equal sched_valid_o, sched_addr_o and sched_data_o in the following cycle.
- R7: sched_i=1 while sched_valid_o=1 removes the shown entry from the ready set, and the entry is then counted as in flight.
- R8: An enqueue with enq_is_replay_i=1 goes back to the slot of the oldest in-flight entry, with the new payload. It keeps that slot's allocation age, becomes waiting (or ready if enq_ready_i=1), and takes no new slot.
- R9: deq_i=1 frees the slot of the oldest in-flight entry.
- R10: almost_full_o is 1 exactly when the number of occupied slots is at least DEPTH-1. A fresh enqueue is never issued while all DEPTH slots are occupied.
- R11: lookup_match_o is 1 when any occupied slot, whatever its state, holds line address fill_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_i | input | 1 | Enqueue strobe |
| enq_addr_i | input | ADDR_W | Line address of a fresh entry |
| enq_data_i | input | DATA_W | Opaque request payload |
| enq_is_replay_i | input | 1 | Entry is a replay returning to its slot |
| enq_ready_i | input | 1 | Entry starts out ready |
| almost_full_o | output | 1 | Occupancy at least DEPTH-1 |
| fill_i | input | 1 | Fill being processed; wake matching entries |
| fill_addr_i | input | ADDR_W | Line address for fill wake-up and match |
| lookup_match_o | output | 1 | Some held entry has line address fill_addr_i |
| sched_i | input | 1 | Pop the shown ready entry |
| sched_valid_o | output | 1 | A ready entry is shown |
| sched_addr_o | output | ADDR_W | Address of the shown entry |
| sched_data_o | output | DATA_W | Payload of the shown entry |
| sched_valid_next_o | output | 1 | Value sched_valid_o takes next cycle |
| sched_addr_next_o | output | ADDR_W | Value sched_addr_o takes next cycle |
| sched_data_next_o | output | DATA_W | Value sched_data_o takes next cycle |
| deq_i | input | 1 | Release the oldest in-flight entry |

## Verification
A fill that matches two of three waiting entries must wake both and leave the third alone. A buffer that woke only one would strand a request, and one that ignored the address would replay a request before its data arrived. The bench checks that the look-ahead outputs predict a pop and a wake-up one cycle early. A stale look-ahead would load the wrong entry downstream. A replay that misses again is checked twice. The almost-full threshold must not move, because a buffer that allocated a fresh slot would stall upstream too early. When the line fills, the older replayed entry must come out ahead of a younger ready one, because a buffer that lost the slot's age would break same-line commit order.

// File: rtl/mhr_pkg.sv
package mhr_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_PEND  = 2'd1,
    SLOT_RDY   = 2'd2,
    SLOT_SCHED = 2'd3
  } slot_st_e;
endpackage

// File: rtl/mhr_slot.sv
module mhr_slot
  import mhr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              reen_i,
  input  logic              rel_i,
  input  logic              pop_i,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              ld_ready_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output slot_st_e          state_o,
  output slot_st_e          state_nxt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_nxt_o,
  output logic [DATA_W-1:0] data_nxt_o
);
  slot_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wake;

  assign wake = fill_i && (st_q == SLOT_PEND) && (addr_q == fill_addr_i);

  always_comb begin
    state_nxt_o = st_q;
    if (alloc_i || reen_i) state_nxt_o = ld_ready_i ? SLOT_RDY : SLOT_PEND;
    else if (rel_i)        state_nxt_o = SLOT_FREE;
    else if (pop_i)        state_nxt_o = SLOT_SCHED;
    else if (wake)         state_nxt_o = SLOT_RDY;
  end

  // replay keeps line address, refreshes payload
  assign addr_nxt_o = alloc_i ? ld_addr_i : addr_q;
  assign data_nxt_o = (alloc_i || reen_i) ? ld_data_i : data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SLOT_FREE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= state_nxt_o;
      addr_q <= addr_nxt_o;
      data_q <= data_nxt_o;
    end
  end

  assign state_o = st_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  a_r4_wake_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && st_q == SLOT_PEND && addr_q == fill_addr_i && !alloc_i && !reen_i && !rel_i && !pop_i)
    |=> (st_q == SLOT_RDY));

  a_r7_pop_from_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (st_q == SLOT_RDY));

  a_r9_release_inflight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i || reen_i) |-> (st_q == SLOT_SCHED));
endmodule

// File: rtl/mhr_pick.sv
module mhr_pick #(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]       cand_i,
  input  logic [DEPTH-1:0]       young_i,
  input  logic [DEPTH*DEPTH-1:0] older_i,   // bit j*DEPTH+i: slot j older than slot i
  output logic                   valid_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [DEPTH-1:0] old_c;
  logic [DEPTH-1:0] new_c;
  logic             beaten;

  assign old_c = cand_i & ~young_i;
  assign new_c = cand_i & young_i;

  always_comb begin
    valid_o = |cand_i;
    idx_o   = '0;
    beaten  = 1'b0;
    if (|old_c) begin
      for (int i = 0; i < DEPTH; i++) begin
        beaten = 1'b0;
        for (int j = 0; j < DEPTH; j++)
          if (j != i && old_c[j] && older_i[j*DEPTH+i]) beaten = 1'b1;
        if (old_c[i] && !beaten) idx_o = IDX_W'(i);
      end
    end else begin
      for (int i = DEPTH-1; i >= 0; i--)
        if (new_c[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/miss_hold_buf.sv
module miss_hold_buf
  import mhr_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_i,
  input  logic [ADDR_W-1:0] enq_addr_i,
  input  logic [DATA_W-1:0] enq_data_i,
  input  logic              enq_is_replay_i,
  input  logic              enq_ready_i,
  output logic              almost_full_o,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  output logic              lookup_match_o,
  input  logic              sched_i,
  output logic              sched_valid_o,
  output logic [ADDR_W-1:0] sched_addr_o,
  output logic [DATA_W-1:0] sched_data_o,
  output logic              sched_valid_next_o,
  output logic [ADDR_W-1:0] sched_addr_next_o,
  output logic [DATA_W-1:0] sched_data_next_o,
  input  logic              deq_i
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  slot_st_e          st_q [DEPTH];
  slot_st_e          st_n [DEPTH];
  logic [ADDR_W-1:0] a_q  [DEPTH];
  logic [ADDR_W-1:0] a_n  [DEPTH];
  logic [DATA_W-1:0] d_q  [DEPTH];
  logic [DATA_W-1:0] d_n  [DEPTH];

  logic [DEPTH-1:0] free_m, rdy_m, rdy_nm, sched_m, match_m, young_m;
  logic [IDX_W-1:0] alloc_idx, cur_idx, nxt_idx, head_idx;
  logic [CNT_W-1:0] used;
  logic             new_enq, rep_enq, pop;

  logic [DEPTH*DEPTH-1:0] older_q;
  logic [IDX_W-1:0]       fifo_q [DEPTH];
  logic [IDX_W-1:0]       rd_q, wr_q;
  logic [CNT_W-1:0]       fcnt_q;

  assign new_enq = enq_i && !enq_is_replay_i;
  assign rep_enq = enq_i && enq_is_replay_i;
  assign pop     = sched_i && sched_valid_o;
  assign head_idx = fifo_q[rd_q];

  always_comb begin
    used      = '0;
    alloc_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      free_m[i]  = (st_q[i] == SLOT_FREE);
      rdy_m[i]   = (st_q[i] == SLOT_RDY);
      rdy_nm[i]  = (st_n[i] == SLOT_RDY);
      sched_m[i] = (st_q[i] == SLOT_SCHED);
      match_m[i] = !free_m[i] && (a_q[i] == fill_addr_i);
      used       = used + CNT_W'(!free_m[i]);
    end
    for (int i = DEPTH-1; i >= 0; i--)
      if (free_m[i]) alloc_idx = IDX_W'(i);
    young_m = '0;
    if (new_enq) young_m[alloc_idx] = 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    mhr_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) slot_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (new_enq && alloc_idx == IDX_W'(g)),
      .reen_i      (rep_enq && head_idx == IDX_W'(g)),
      .rel_i       (deq_i && head_idx == IDX_W'(g)),
      .pop_i       (pop && cur_idx == IDX_W'(g)),
      .fill_i      (fill_i),
      .fill_addr_i (fill_addr_i),
      .ld_ready_i  (enq_ready_i),
      .ld_addr_i   (enq_addr_i),
      .ld_data_i   (enq_data_i),
      .state_o     (st_q[g]),
      .state_nxt_o (st_n[g]),
      .addr_o      (a_q[g]),
      .data_o      (d_q[g]),
      .addr_nxt_o  (a_n[g]),
      .data_nxt_o  (d_n[g])
    );
  end

  mhr_pick #(.DEPTH(DEPTH)) pick_cur_i (
    .cand_i  (rdy_m),
    .young_i ({DEPTH{1'b0}}),
    .older_i (older_q),
    .valid_o (sched_valid_o),
    .idx_o   (cur_idx)
  );

  mhr_pick #(.DEPTH(DEPTH)) pick_nxt_i (
    .cand_i  (rdy_nm),
    .young_i (young_m),
    .older_i (older_q),
    .valid_o (sched_valid_next_o),
    .idx_o   (nxt_idx)
  );

  assign sched_addr_o      = a_q[cur_idx];
  assign sched_data_o      = d_q[cur_idx];
  assign sched_addr_next_o = a_n[nxt_idx];
  assign sched_data_next_o = d_n[nxt_idx];
  assign lookup_match_o    = |match_m;
  assign almost_full_o     = (used >= CNT_W'(DEPTH - 1));

  // age matrix: fresh slot becomes youngest; replay keeps its row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else if (new_enq) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (IDX_W'(j) != alloc_idx) begin
          older_q[j*DEPTH + int'(alloc_idx)] <= 1'b1;
          older_q[int'(alloc_idx)*DEPTH + j] <= 1'b0;
        end
      end
    end
  end

  // in-flight replays in issue order
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      fcnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) fifo_q[i] <= '0;
    end else begin
      if (pop) begin
        fifo_q[wr_q] <= cur_idx;
        wr_q <= (wr_q == IDX_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      end
      if (rep_enq || deq_i)
        rd_q <= (rd_q == IDX_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      fcnt_q <= fcnt_q + CNT_W'(pop) - CNT_W'(rep_enq || deq_i);
    end
  end

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  a_r6_lookahead_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (sched_valid_o == $past(sched_valid_next_o)));

  a_r6_lookahead_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && sched_valid_o) |->
      (sched_addr_o == $past(sched_addr_next_o) && sched_data_o == $past(sched_data_next_o)));

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_enq |-> (used != CNT_W'(DEPTH)));

  a_r8_replay_keeps_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_enq |=> (used == $past(used)));

  a_r9_inflight_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_enq || deq_i) |-> (fcnt_q != '0 && $countones(sched_m) == int'(fcnt_q)));

  a_r7_pop_inflight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !rep_enq && !deq_i) |=> ($countones(sched_m) == $past($countones(sched_m)) + 1));
endmodule

// File: tb/miss_hold_buf_tb_top.sv
`timescale 1ns/1ps
module miss_hold_buf_tb_top;
  localparam int DEPTH = 4, ADDR_W = 8, DATA_W = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enq_i = 0, enq_is_replay_i = 0, enq_ready_i = 0;
  logic [ADDR_W-1:0] enq_addr_i = '0, fill_addr_i = '0;
  logic [DATA_W-1:0] enq_data_i = '0;
  logic fill_i = 0, sched_i = 0, deq_i = 0;
  logic almost_full_o, lookup_match_o, sched_valid_o, sched_valid_next_o;
  logic [ADDR_W-1:0] sched_addr_o, sched_addr_next_o;
  logic [DATA_W-1:0] sched_data_o, sched_data_next_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  miss_hold_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_i(enq_i), .enq_addr_i(enq_addr_i), .enq_data_i(enq_data_i),
    .enq_is_replay_i(enq_is_replay_i), .enq_ready_i(enq_ready_i),
    .almost_full_o(almost_full_o),
    .fill_i(fill_i), .fill_addr_i(fill_addr_i), .lookup_match_o(lookup_match_o),
    .sched_i(sched_i), .sched_valid_o(sched_valid_o),
    .sched_addr_o(sched_addr_o), .sched_data_o(sched_data_o),
    .sched_valid_next_o(sched_valid_next_o),
    .sched_addr_next_o(sched_addr_next_o), .sched_data_next_o(sched_data_next_o),
    .deq_i(deq_i)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step();
    @(posedge clk); #1;
    enq_i = 0; enq_is_replay_i = 0; enq_ready_i = 0;
    fill_i = 0; sched_i = 0; deq_i = 0;
    #1;
  endtask

  task automatic enq(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                     input bit rep, input bit rdy);
    enq_i = 1; enq_addr_i = a; enq_data_i = d; enq_is_replay_i = rep; enq_ready_i = rdy;
    step();
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a);
    fill_i = 1; fill_addr_i = a; step();
  endtask

  task automatic pop();   sched_i = 1; step(); endtask
  task automatic rel();   deq_i = 1;   step(); endtask

  task automatic probe(input logic [ADDR_W-1:0] a, input bit exp, input string req);
    fill_addr_i = a; #1;
    chk_eq(req, lookup_match_o, exp);
  endtask

  task automatic t_reset();
    chk_eq("R1 sched_valid", sched_valid_o, 0);
    chk_eq("R1 sched_valid_next", sched_valid_next_o, 0);
    chk_eq("R1 almost_full", almost_full_o, 0);
    probe(8'h10, 0, "R1 lookup_match");
  endtask

  task automatic t_wake_many();
    enq(8'h10, 16'h0001, 0, 0);
    chk_eq("R10 af at 1", almost_full_o, 0);
    enq(8'h20, 16'h0002, 0, 0);
    chk_eq("R10 af at 2", almost_full_o, 0);
    enq(8'h10, 16'h0003, 0, 0);
    chk_eq("R10 af at 3", almost_full_o, 1);
    chk_eq("R2 waiting not shown", sched_valid_o, 0);
    probe(8'h10, 1, "R11 match held line");
    probe(8'h30, 0, "R11 no match other line");
    fill_i = 1; fill_addr_i = 8'h10; #1;
    chk_eq("R6 next valid on wake", sched_valid_next_o, 1);
    chk_eq("R6 next data on wake", sched_data_next_o, 16'h0001);
    chk_eq("R6 current still idle", sched_valid_o, 0);
    step();
    chk_eq("R4 woken valid", sched_valid_o, 1);
    chk_eq("R5 oldest first", sched_data_o, 16'h0001);
    chk_eq("R4 woken addr", sched_addr_o, 8'h10);
    sched_i = 1; #1;
    chk_eq("R6 next after pop", sched_data_next_o, 16'h0003);
    step();
    chk_eq("R5 R7 second same-line", sched_data_o, 16'h0003);
    pop();
    chk_eq("R4 other line still waiting", sched_valid_o, 0);
    rel();
    chk_eq("R9 af after one release", almost_full_o, 0);
    rel();
    probe(8'h10, 0, "R9 line released");
    fill(8'h20);
    chk_eq("R4 second line woken", sched_data_o, 16'h0002);
    pop();
    rel();
    probe(8'h20, 0, "R9 empty again");
  endtask

  task automatic t_insert_ready();
    enq(8'h40, 16'h0004, 0, 1);
    chk_eq("R3 ready insert valid", sched_valid_o, 1);
    chk_eq("R3 ready insert data", sched_data_o, 16'h0004);
    chk_eq("R3 ready insert addr", sched_addr_o, 8'h40);
  endtask

  task automatic t_replay_miss();
    pop();
    chk_eq("R7 popped leaves ready", sched_valid_o, 0);
    enq(8'h00, 16'h0044, 1, 0);
    chk_eq("R8 replay waits", sched_valid_o, 0);
    probe(8'h40, 1, "R8 replay keeps line");
    chk_eq("R8 no new slot", almost_full_o, 0);
    enq(8'h50, 16'h0005, 0, 1);
    chk_eq("R8 af with two", almost_full_o, 0);
    chk_eq("R3 younger ready shown", sched_data_o, 16'h0005);
    enq(8'h60, 16'h0006, 0, 0);
    chk_eq("R10 af with three", almost_full_o, 1);
    fill(8'h40);
    chk_eq("R5 R8 replay keeps age", sched_data_o, 16'h0044);
    pop();
    chk_eq("R7 next ready", sched_data_o, 16'h0005);
    pop();
    rel();
    rel();
    fill(8'h60);
    chk_eq("R4 last line", sched_data_o, 16'h0006);
    pop();
    rel();
    probe(8'h60, 0, "R9 all released");
    chk_eq("R10 af empty", almost_full_o, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_ni = 1; #1;
        t_reset();
        t_wake_many();
        t_insert_ready();
        t_replay_miss();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule